// File: doc/BRIEF.md
# Branch Trace Capture Buffer

This block sits beside a processor core and watches the stream of committed instruction addresses. Each cycle the core may report one retired instruction: its address, whether it is a 16-bit or a 32-bit instruction, and whether control reached it asynchronously (an exception entry or return, or a debugger writing the PC). The block remembers the previous instruction. When the new address is not the fall-through address of the previous one, the flow of control was broken. While tracing is enabled, the block then emits one 64-bit record into a circular buffer in on-chip SRAM. The low word holds the address the PC left, and the high word holds the address it arrived at.

Instruction addresses are always even, so bit 0 of each word is free for a flag. In the source word, bit 0 marks an asynchronous change. In the destination word, bit 0 marks the first record of a new trace session. An exception return shows up as two jumps if the core reports the magic return address as a retired PC: one jump into that address and one out of it.

Software reaches the block through a small register port:
- offset 0x00 holds the position: the write offset in bits [12:3] and a sticky wrap flag in bit 2.
- offset 0x04 is the control word: the run bit in bit 31 and a 5-bit size code in bits [4:0].
- offset 0x08 holds the stop-when-full bit in bit 0.
- offset 0x0C returns the fixed buffer base address.

The buffer holds 2^(code+4) bytes, clamped to an implemented maximum. With the wrap flag clear, the oldest record is at offset 0. With the wrap flag set, the oldest record is at the current offset.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset the position register, control word and stop-when-full bit all read 0, and no SRAM write is issued.
- R2: A retired instruction whose address equals the previous address plus 2 (16-bit) or plus 4 (32-bit) produces no record. The first instruction after reset never produces a record.
- R3: A discontinuous retired address while the run bit is 1 issues exactly one SRAM write in the following cycle. The write goes to base plus the current offset, with data bits [31:0] = previous address with bit 0 replaced by the A flag, and bits [63:32] = new address with bit 0 replaced by the S flag.
- R4: The A flag (record bit 0) equals the asynchronous input of the instruction that arrived at the new address.
- R5: The S flag (record bit 32) is 1 only on the first record written after the run bit goes from 0 to 1. Every later record in that session has it at 0.
- R6: After each record the offset advances by 8 modulo the buffer size. Rolling over to offset 0 sets the wrap flag, which stays set until software writes the position register.
- R7: A size code above the implemented maximum (9 by default) gives the maximum buffer size of 8192 bytes.
- R8: While the run bit is 0 no record is written. Clearing the run bit takes effect for the next retired instruction.
- R9: With the stop-when-full bit set, the record written at the last slot of the buffer is completed, and the run bit then clears by itself.
- R10: Writing the position register loads the offset (bits [12:3]) and the wrap flag (bit 2) directly. Offset 0x0C always reads the base address and ignores writes. Offsets 0x10 to 0x1C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | An instruction retired this cycle |
| commit_pc | input | 32 | Address of the retired instruction (even) |
| commit_wide | input | 1 | 1 for a 32-bit instruction, 0 for a 16-bit one |
| commit_async | input | 1 | Control reached this instruction through an exception or debugger |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_we | output | 1 | SRAM write strobe for one record |
| mem_addr | output | 32 | SRAM byte address of the record |
| mem_wdata | output | 64 | Record: source word low, destination word high |

## Verification
The bench aims at four kinds of mistake:
- Fall-through arithmetic: a design that confuses 2-byte and 4-byte steps logs straight-line code or misses real jumps.
- Session marker: a marker that is not re-armed on re-enable, or not cleared after the first record, hides or invents session boundaries.
- Rollover: wrong masking or a non-sticky wrap flag places the oldest record wrongly, and the clamp of oversized size codes is checked at the 8192-byte top slot.
- Stop-when-full: a design that drops the final record, or stops one slot early, loses the newest history.

// File: rtl/branch_trace_buf.sv
module branch_trace_buf #(
  parameter logic [31:0] BASE_ADDR = 32'h2007_E000,
  parameter int          MAX_MASK  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit_valid,
  input  logic [31:0] commit_pc,
  input  logic        commit_wide,
  input  logic        commit_async,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [63:0] mem_wdata
);
  localparam int OW = MAX_MASK + 4;

  logic [OW-1:0] off_q;
  logic          wrap_q, en_q, halt_q, s_pend_q, have_q, last_wide_q;
  logic [4:0]    mask_q;
  logic [31:0]   last_pc_q;

  wire [4:0]    eff_mask = (mask_q > 5'(MAX_MASK)) ? 5'(MAX_MASK) : mask_q;
  wire [OW:0]   size_b   = (OW+1)'(1) << (eff_mask + 5'd4);
  wire [OW-1:0] size_m   = OW'(size_b - 1'b1);
  wire [31:0]   seq_pc   = last_pc_q + (last_wide_q ? 32'd4 : 32'd2);
  wire          jump     = commit_valid && have_q && (commit_pc != seq_pc);
  wire          cap      = jump && en_q;
  wire [OW-1:0] nxt_off  = (off_q + OW'(8)) & size_m;
  wire          rolled   = (nxt_off == '0);
  wire          wr_pos   = reg_wr && reg_addr[4:2] == 3'd0;
  wire          wr_mst   = reg_wr && reg_addr[4:2] == 3'd1;
  wire          wr_flow  = reg_wr && reg_addr[4:2] == 3'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0; wrap_q <= 1'b0; en_q <= 1'b0; halt_q <= 1'b0;
      s_pend_q <= 1'b0; have_q <= 1'b0; last_wide_q <= 1'b0;
      mask_q <= '0; last_pc_q <= '0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= cap;
      if (cap) begin
        mem_addr  <= BASE_ADDR + 32'(off_q & size_m);
        mem_wdata <= {commit_pc[31:1], s_pend_q, last_pc_q[31:1], commit_async};
        s_pend_q  <= 1'b0;
      end
      if (commit_valid) begin
        have_q      <= 1'b1;
        last_pc_q   <= commit_pc;
        last_wide_q <= commit_wide;
      end
      if (wr_pos) begin
        off_q  <= {reg_wdata[OW-1:3], 3'b000};
        wrap_q <= reg_wdata[2];
      end else if (cap) begin
        off_q <= nxt_off;
        if (rolled) wrap_q <= 1'b1;
      end
      if (wr_mst) begin
        en_q   <= reg_wdata[31];
        mask_q <= reg_wdata[4:0];
        if (reg_wdata[31] && !en_q) s_pend_q <= 1'b1;
      end else if (cap && rolled && halt_q) begin
        en_q <= 1'b0;
      end
      if (wr_flow) halt_q <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr[4:2])
      3'd0:    reg_rdata = 32'({off_q[OW-1:3], wrap_q, 2'b00});
      3'd1:    reg_rdata = {en_q, 26'd0, mask_q};
      3'd2:    reg_rdata = {31'd0, halt_q};
      3'd3:    reg_rdata = BASE_ADDR;
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_rec_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[2:0] == 3'd0) && ((mem_addr - BASE_ADDR) < (32'd1 << OW)));

  assert_seq_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && have_q && (commit_pc == seq_pc) |=> !mem_we);

  assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q && !wr_pos |=> wrap_q);

  assert_off_in_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !wr_pos && !wr_mst |=> (off_q & ~size_m) == '0);

  assert_sflag_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !$past(wr_mst) |-> !s_pend_q);
endmodule

// File: tb/sim_branch_trace_buf.sv
module sim_branch_trace_buf;
  localparam int PERIOD = 10;
  localparam logic [31:0] BASE = 32'h2007_E000;

  logic clk = 0, rst_n = 0;
  logic commit_valid = 0, commit_wide = 0, commit_async = 0, reg_wr = 0;
  logic [31:0] commit_pc = 0, reg_wdata = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_rdata, mem_addr;
  logic [63:0] mem_wdata;
  logic mem_we;

  int total = 0, bad = 0;
  logic m_en = 0, m_halt = 0, m_wrap = 0, m_sp = 0, m_have = 0, m_wide = 0;
  logic [4:0] m_mask = 0;
  logic [31:0] m_off = 0, m_last = 0;

  always #(PERIOD/2) clk = ~clk;

  branch_trace_buf u0 (.clk, .rst_n, .commit_valid, .commit_pc, .commit_wide, .commit_async,
    .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .mem_we, .mem_addr, .mem_wdata);

  function automatic logic [31:0] sz_mask();
    int e = (m_mask > 9) ? 9 : int'(m_mask);
    return (32'd1 << (e + 4)) - 1;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic commit(logic [31:0] pc, logic wide, logic async_f, string req);
    logic ew;
    logic [63:0] ed;
    logic [31:0] ea;
    @(negedge clk);
    commit_valid = 1; commit_pc = pc; commit_wide = wide; commit_async = async_f;
    ew = m_en && m_have && (pc != m_last + (m_wide ? 32'd4 : 32'd2));
    ed = {pc[31:1], m_sp, m_last[31:1], async_f};
    ea = BASE + (m_off & sz_mask());
    @(posedge clk); #1;
    commit_valid = 0;
    chk(mem_we == ew, {req, " we"}, 64'(mem_we), 64'(ew));
    if (ew && mem_we) begin
      chk(mem_addr == ea, {req, " addr"}, 64'(mem_addr), 64'(ea));
      chk(mem_wdata == ed, {req, " data"}, mem_wdata, ed);
    end
    if (ew) begin
      m_off = (m_off + 8) & sz_mask();
      m_sp = 0;
      if (m_off == 0) begin m_wrap = 1; if (m_halt) m_en = 0; end
    end
    m_have = 1; m_last = pc; m_wide = wide;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    case (a[4:2])
      3'd0: begin m_off = d & 32'h1FF8; m_wrap = d[2]; end
      3'd1: begin if (d[31] && !m_en) m_sp = 1; m_en = d[31]; m_mask = d[4:0]; end
      3'd2: m_halt = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a; #1;
    chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(5'h00, 0, "R1 position");
    rd(5'h04, 0, "R1 control");
    rd(5'h08, 0, "R1 flow");
    chk(mem_we == 0, "R1 we", 64'(mem_we), 0);

    commit(32'h100, 0, 0, "R2 first");
    wr(5'h04, 32'h8000_0000);
    commit(32'h102, 1, 0, "R2 seq narrow");
    commit(32'h106, 0, 0, "R2 seq wide");
    commit(32'h200, 0, 0, "R3 R5 first record");
    commit(32'h300, 0, 1, "R4 async");
    rd(5'h00, 32'h4, "R6 wrap set");
    commit(32'h302, 0, 0, "R2 seq after async");
    rd(5'h00, 32'h4, "R6 wrap sticky");

    wr(5'h04, 32'h8000_001F);
    wr(5'h00, 32'h1FF8);
    commit(32'h400, 1, 0, "R7 clamp top slot");
    rd(5'h00, 32'h4, "R7 clamp rollover");

    wr(5'h04, 32'h0);
    commit(32'h500, 0, 0, "R8 disabled");
    wr(5'h04, 32'h8000_0001);
    commit(32'h600, 0, 0, "R5 rearm");
    commit(32'h680, 0, 0, "R5 second");

    wr(5'h08, 32'h1);
    wr(5'h00, 32'h18);
    commit(32'h700, 0, 0, "R9 last slot");
    rd(5'h04, 32'h1, "R9 auto stop");
    commit(32'h800, 0, 0, "R9 stopped");

    wr(5'h0C, 32'h0);
    rd(5'h0C, BASE, "R10 base");
    rd(5'h10, 0, "R10 reserved");
    rd(5'h1C, 0, "R10 reserved top");
    wr(5'h00, 32'h2C);
    rd(5'h00, 32'h2C, "R10 position load");
    wr(5'h08, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      if (r < 3) wr(5'h04, {1'($urandom), 26'd0, 5'($urandom % 16)});
      else if (r < 4) wr(5'h00, $urandom & 32'h1FFC);
      else if (r < 5) rd(5'h00, 32'(m_off | {m_wrap, 2'b00}), "R6 random position");
      else begin
        logic [31:0] pc;
        if ($urandom % 10 < 7) pc = m_last + (m_wide ? 32'd4 : 32'd2);
        else pc = $urandom & 32'hFFFF_FFFE;
        commit(pc, 1'($urandom), 1'($urandom), "R3 random");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule